// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block sits between an 8-bit host processor bus and the configuration side of a serial bus controller. A mode pin picks the bus style. With the pin low, the host shares the data lines with the low address byte: the block captures that byte while the address-latch strobe is high, and it answers only when the separate high address byte equals 0x80 and the captured low byte is no greater than 0x4C. With the pin high, the address lines carry the register address directly, the latch strobe has no effect, and the block answers for addresses 0x00 to 0x4C.

The block holds the setup, acceptance-mask and trigger-identifier registers and hands their values to the protocol engine. Writes to some bits do not store anything. Instead they fire one-cycle command pulses toward the engine: start or abort a transmission, reset the controller, clear receive flags, and clear the interrupt. The engine reports its status, error counters and events through plain inputs. The block turns enabled events into an active-low interrupt that stays asserted until the host clears it. The data bus is split into input, output and output-enable, and the pad ring joins them into one bidirectional pin.

Top module: `hostbus_regif`

## Requirements
- R1: After reset, address 0x00 reads 0x00, 0x01 reads 0x80, 0x02 reads 0x59, 0x03 reads 0x02, and the mask (0x07, 0x08) and trigger (0x0B, 0x0C) registers read 0x00. irq_n is 1.
- R2: With mode_sel=1, addr_bus is the register address over 0x00..0x4C. ALE and the state of data_in during the address phase have no effect on which register is accessed.
- R3: With mode_sel=0, the low address byte is taken from data_in on every clock edge while ale=1. The block is selected only when addr_bus=0x80 and that low byte is at most 0x4C. Writes outside this window are ignored, and reads outside it return 0x00.
- R4: A register write happens on a rising clock edge with cs=1, wr_n=0 and rd_n=1. Cycles with cs=0, or with rd_n=0, store nothing.
- R5: data_oe is 1 exactly while cs=1, rd_n=0 and wr_n=1. During that time data_out carries the addressed register.
- R6: Writing 0x03 fires a one-cycle pulse for each set bit among bit 3 (cmd_txreq), bit 4 (cmd_abort), bit 5 (interrupt clear), bit 6 (cmd_ctrl_rst) and bit 7 (cmd_rxclr_all). Only the first clock of a write fires pulses, however long the write lasts. These bits are not stored, so 0x03 reads back {5'b0, bits 2:0}.
- R7: Writing 0x04 fires a one-cycle pulse on cmd_rxclr[b] for each set bit b in bits 2:0. Address 0x04 reads 0x00.
- R8: The interrupt sources have enable bits at 0x00: bit 0 for ev_tx_done, bit 1 for ev_rx_done, bit 2 for ev_overrun and bit 3 for the error condition. An enabled event drives irq_n to 0 on the next clock. irq_n stays 0 until an interrupt-clear command. A disabled event leaves irq_n at 1.
- R9: The error source fires on the rising edge of (err_passive OR bus_off). A level that stays high does not raise the interrupt again after it has been cleared.
- R10: Reads of 0x05, 0x06, 0x09 and 0x0A return stat_main, stat_rx, err_cnt_tx and err_cnt_rx. Writes to these addresses are ignored. Unmapped addresses inside the window read 0x00 and ignore writes.
- R11: acc_mask and trig_id are 11 bits wide. Addresses 0x07 and 0x0B hold bits 10:3 of each. Bits 7:5 of 0x08 and 0x0C hold bits 2:0. The low five bits of 0x08 and 0x0C read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 1 | 0: multiplexed bus with window decode, 1: separate address bus |
| cs | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| ale | input | 1 | Address-latch strobe (mode 0 only) |
| addr_bus | input | 8 | High address byte (mode 0) or register address (mode 1) |
| data_in | input | 8 | Data from pad; low address byte in mode 0 |
| data_out | output | 8 | Read data to pad |
| data_oe | output | 1 | Pad output enable; 0 releases the bus |
| ev_tx_done | input | 1 | Transmission completed (one-cycle event) |
| ev_rx_done | input | 1 | Data frame received (one-cycle event) |
| ev_overrun | input | 1 | Receive buffer overrun (one-cycle event) |
| err_passive | input | 1 | Error-passive level |
| bus_off | input | 1 | Bus-off level |
| stat_main | input | 8 | Engine status byte |
| stat_rx | input | 8 | Receive status byte |
| err_cnt_tx | input | 8 | Transmit error counter |
| err_cnt_rx | input | 8 | Receive error counter |
| cfg_setup0 | output | 8 | Setup register 0 (interrupt enables in bits 3:0) |
| cfg_setup1 | output | 8 | Setup register 1 |
| cfg_timing | output | 8 | Bit-timing register |
| cfg_rsj | output | 3 | Resync-jump field |
| acc_mask | output | 11 | Acceptance mask |
| trig_id | output | 11 | Trigger identifier |
| cmd_txreq | output | 1 | Transmit-request pulse |
| cmd_abort | output | 1 | Abort pulse |
| cmd_ctrl_rst | output | 1 | Controller-reset pulse |
| cmd_rxclr_all | output | 1 | Clear-all-receive-flags pulse |
| cmd_rxclr | output | 3 | Per-buffer receive-clear pulses |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The assertions check four things on every cycle. A setup register changes only after a qualified write. In mode 0 it changes only under the 0x80 high byte. Command pulses are one cycle wide and follow a write. irq_n falls only after an enabled event and stays low until the interrupt clear. The bench scenarios cover the rest: exact reset values, read-back layout of the split mask and trigger fields, that an out-of-window or gated write stores nothing, that a long write fires a command only once, and the edge-only behaviour of the error source.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
  localparam int BUS_W = 8;
  localparam int RSJ_W = 3;
  localparam int EN_W  = 4;

  localparam logic [BUS_W-1:0] A_SETUP0  = 8'h00;
  localparam logic [BUS_W-1:0] A_SETUP1  = 8'h01;
  localparam logic [BUS_W-1:0] A_TIMING  = 8'h02;
  localparam logic [BUS_W-1:0] A_CTRL    = 8'h03;
  localparam logic [BUS_W-1:0] A_RXCLR   = 8'h04;
  localparam logic [BUS_W-1:0] A_STAT    = 8'h05;
  localparam logic [BUS_W-1:0] A_STATRX  = 8'h06;
  localparam logic [BUS_W-1:0] A_MASK_HI = 8'h07;
  localparam logic [BUS_W-1:0] A_MASK_LO = 8'h08;
  localparam logic [BUS_W-1:0] A_ERRTX   = 8'h09;
  localparam logic [BUS_W-1:0] A_ERRRX   = 8'h0A;
  localparam logic [BUS_W-1:0] A_TRIG_HI = 8'h0B;
  localparam logic [BUS_W-1:0] A_TRIG_LO = 8'h0C;

  localparam logic [BUS_W-1:0] RST_SETUP1 = 8'h80;
  localparam logic [BUS_W-1:0] RST_TIMING = 8'h59;
  localparam logic [RSJ_W-1:0] RST_RSJ    = 3'd2;

  // command bit positions in the control register
  localparam int CB_TXREQ  = 3;
  localparam int CB_ABORT  = 4;
  localparam int CB_INTCLR = 5;
  localparam int CB_CRST   = 6;
  localparam int CB_RXALL  = 7;

  // window decode: mode 1 plain range, mode 0 needs matching high byte
  function automatic logic addr_hit(input logic mode, input logic [BUS_W-1:0] bus,
                                    input logic [BUS_W-1:0] low, input logic [BUS_W-1:0] hi,
                                    input logic [BUS_W-1:0] last);
    if (mode) return (bus <= last);
    return (bus == hi) && (low <= last);
  endfunction

  // any enabled interrupt source
  function automatic logic irq_any(input logic [EN_W-1:0] en, input logic tx,
                                   input logic rx, input logic ov, input logic er);
    return (en[0] & tx) | (en[1] & rx) | (en[2] & ov) | (en[3] & er);
  endfunction
endpackage

// File: rtl/hostbus_decode.sv
module hostbus_decode
  import hostbus_pkg::*;
#(
  parameter logic [BUS_W-1:0] WIN_HI    = 8'h80,
  parameter logic [BUS_W-1:0] LAST_ADDR = 8'h4C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             ale,
  input  logic [BUS_W-1:0] addr_bus,
  input  logic [BUS_W-1:0] data_in,
  output logic [BUS_W-1:0] reg_addr,
  output logic             sel
);
  logic [BUS_W-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   low_q <= '0;
    else if (ale) low_q <= data_in;
  end

  assign reg_addr = mode_sel ? addr_bus : low_q;
  assign sel      = addr_hit(mode_sel, addr_bus, low_q, WIN_HI, LAST_ADDR);
endmodule

// File: rtl/hostbus_regs.sv
module hostbus_regs
  import hostbus_pkg::*;
#(
  parameter int NBUF = 3,
  parameter int ID_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [BUS_W-1:0] reg_addr,
  input  logic             cs,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic [BUS_W-1:0] data_in,
  input  logic [BUS_W-1:0] stat_main,
  input  logic [BUS_W-1:0] stat_rx,
  input  logic [BUS_W-1:0] err_cnt_tx,
  input  logic [BUS_W-1:0] err_cnt_rx,
  output logic [BUS_W-1:0] data_out,
  output logic             data_oe,
  output logic [BUS_W-1:0] setup0,
  output logic [BUS_W-1:0] setup1,
  output logic [BUS_W-1:0] timing,
  output logic [RSJ_W-1:0] rsj,
  output logic [ID_W-1:0]  acc_mask,
  output logic [ID_W-1:0]  trig_id,
  output logic             cmd_txreq,
  output logic             cmd_abort,
  output logic             cmd_intclr,
  output logic             cmd_ctrl_rst,
  output logic             cmd_rxclr_all,
  output logic [NBUF-1:0]  cmd_rxclr
);
  localparam int LO_W  = ID_W - BUS_W;
  localparam int PAD_W = BUS_W - LO_W;

  logic wr_act, wr_prev, wr_en, wr_first, ctrl_first;

  assign wr_act     = cs & ~wr_n & rd_n;
  assign wr_en      = wr_act & sel;
  assign wr_first   = wr_en & ~wr_prev;
  assign ctrl_first = wr_first && (reg_addr == A_CTRL);
  assign data_oe    = cs & ~rd_n & wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev  <= 1'b0;
      setup0   <= '0;
      setup1   <= RST_SETUP1;
      timing   <= RST_TIMING;
      rsj      <= RST_RSJ;
      acc_mask <= '0;
      trig_id  <= '0;
    end else begin
      wr_prev <= wr_act;
      if (wr_en) begin
        case (reg_addr)
          A_SETUP0:  setup0 <= data_in;
          A_SETUP1:  setup1 <= data_in;
          A_TIMING:  timing <= data_in;
          A_CTRL:    rsj    <= data_in[RSJ_W-1:0];
          A_MASK_HI: acc_mask[ID_W-1:LO_W] <= data_in;
          A_MASK_LO: acc_mask[LO_W-1:0]    <= data_in[BUS_W-1 -: LO_W];
          A_TRIG_HI: trig_id[ID_W-1:LO_W]  <= data_in;
          A_TRIG_LO: trig_id[LO_W-1:0]     <= data_in[BUS_W-1 -: LO_W];
          default: ;
        endcase
      end
    end
  end

  // command strobes: registered, one per write pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_txreq     <= 1'b0;
      cmd_abort     <= 1'b0;
      cmd_intclr    <= 1'b0;
      cmd_ctrl_rst  <= 1'b0;
      cmd_rxclr_all <= 1'b0;
    end else begin
      cmd_txreq     <= ctrl_first & data_in[CB_TXREQ];
      cmd_abort     <= ctrl_first & data_in[CB_ABORT];
      cmd_intclr    <= ctrl_first & data_in[CB_INTCLR];
      cmd_ctrl_rst  <= ctrl_first & data_in[CB_CRST];
      cmd_rxclr_all <= ctrl_first & data_in[CB_RXALL];
    end
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_rxclr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_rxclr[b] <= 1'b0;
      else        cmd_rxclr[b] <= wr_first && (reg_addr == A_RXCLR) && data_in[b];
    end
  end

  logic [BUS_W-1:0] rd_mux;
  always_comb begin
    case (reg_addr)
      A_SETUP0:  rd_mux = setup0;
      A_SETUP1:  rd_mux = setup1;
      A_TIMING:  rd_mux = timing;
      A_CTRL:    rd_mux = {{(BUS_W-RSJ_W){1'b0}}, rsj};
      A_STAT:    rd_mux = stat_main;
      A_STATRX:  rd_mux = stat_rx;
      A_MASK_HI: rd_mux = acc_mask[ID_W-1:LO_W];
      A_MASK_LO: rd_mux = {acc_mask[LO_W-1:0], {PAD_W{1'b0}}};
      A_ERRTX:   rd_mux = err_cnt_tx;
      A_ERRRX:   rd_mux = err_cnt_rx;
      A_TRIG_HI: rd_mux = trig_id[ID_W-1:LO_W];
      A_TRIG_LO: rd_mux = {trig_id[LO_W-1:0], {PAD_W{1'b0}}};
      default:   rd_mux = '0;
    endcase
  end

  assign data_out = sel ? rd_mux : '0;
endmodule

// File: rtl/hostbus_irq.sv
module hostbus_irq
  import hostbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EN_W-1:0] en,
  input  logic            ev_tx,
  input  logic            ev_rx,
  input  logic            ev_ov,
  input  logic            err_lvl,
  input  logic            clr,
  output logic            err_rise,
  output logic            irq_n
);
  logic err_q, pend_q, set_now;

  assign err_rise = err_lvl & ~err_q;
  assign set_now  = irq_any(en, ev_tx, ev_rx, ev_ov, err_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      err_q  <= err_lvl;
      pend_q <= set_now | (pend_q & ~clr);
    end
  end

  assign irq_n = ~pend_q;
endmodule

// File: rtl/hostbus_regif.sv
module hostbus_regif
  import hostbus_pkg::*;
#(
  parameter logic [BUS_W-1:0] WIN_HI    = 8'h80,
  parameter logic [BUS_W-1:0] LAST_ADDR = 8'h4C,
  parameter int               NBUF      = 3,
  parameter int               ID_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             cs,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             ale,
  input  logic [BUS_W-1:0] addr_bus,
  input  logic [BUS_W-1:0] data_in,
  output logic [BUS_W-1:0] data_out,
  output logic             data_oe,
  input  logic             ev_tx_done,
  input  logic             ev_rx_done,
  input  logic             ev_overrun,
  input  logic             err_passive,
  input  logic             bus_off,
  input  logic [BUS_W-1:0] stat_main,
  input  logic [BUS_W-1:0] stat_rx,
  input  logic [BUS_W-1:0] err_cnt_tx,
  input  logic [BUS_W-1:0] err_cnt_rx,
  output logic [BUS_W-1:0] cfg_setup0,
  output logic [BUS_W-1:0] cfg_setup1,
  output logic [BUS_W-1:0] cfg_timing,
  output logic [RSJ_W-1:0] cfg_rsj,
  output logic [ID_W-1:0]  acc_mask,
  output logic [ID_W-1:0]  trig_id,
  output logic             cmd_txreq,
  output logic             cmd_abort,
  output logic             cmd_ctrl_rst,
  output logic             cmd_rxclr_all,
  output logic [NBUF-1:0]  cmd_rxclr,
  output logic             irq_n
);
  logic [BUS_W-1:0] reg_addr;
  logic             sel;
  logic             intclr;
  logic             err_rise;

  hostbus_decode #(.WIN_HI(WIN_HI), .LAST_ADDR(LAST_ADDR)) u_dec (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ale(ale),
    .addr_bus(addr_bus), .data_in(data_in), .reg_addr(reg_addr), .sel(sel)
  );

  hostbus_regs #(.NBUF(NBUF), .ID_W(ID_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .reg_addr(reg_addr),
    .cs(cs), .wr_n(wr_n), .rd_n(rd_n), .data_in(data_in),
    .stat_main(stat_main), .stat_rx(stat_rx),
    .err_cnt_tx(err_cnt_tx), .err_cnt_rx(err_cnt_rx),
    .data_out(data_out), .data_oe(data_oe),
    .setup0(cfg_setup0), .setup1(cfg_setup1), .timing(cfg_timing), .rsj(cfg_rsj),
    .acc_mask(acc_mask), .trig_id(trig_id),
    .cmd_txreq(cmd_txreq), .cmd_abort(cmd_abort), .cmd_intclr(intclr),
    .cmd_ctrl_rst(cmd_ctrl_rst), .cmd_rxclr_all(cmd_rxclr_all), .cmd_rxclr(cmd_rxclr)
  );

  hostbus_irq u_irq (
    .clk(clk), .rst_n(rst_n), .en(cfg_setup0[EN_W-1:0]),
    .ev_tx(ev_tx_done), .ev_rx(ev_rx_done), .ev_ov(ev_overrun),
    .err_lvl(err_passive | bus_off), .clr(intclr),
    .err_rise(err_rise), .irq_n(irq_n)
  );
endmodule

// File: rtl/hostbus_regif_chk.sv
module hostbus_regif_chk #(
  parameter logic [7:0] WIN_HI = 8'h80
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_sel,
  input logic       cs,
  input logic       wr_n,
  input logic       rd_n,
  input logic [7:0] addr_bus,
  input logic [7:0] cfg_setup0,
  input logic [7:0] cfg_setup1,
  input logic       cmd_txreq,
  input logic       ev_tx_done,
  input logic       ev_rx_done,
  input logic       ev_overrun,
  input logic       err_rise,
  input logic       intclr,
  input logic       irq_n
);
  // R4
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(cfg_setup0) |-> $past(cs && !wr_n && rd_n));

  // R3
  win_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && $changed(cfg_setup1)) |-> ($past(addr_bus) == WIN_HI));

  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_txreq |=> !cmd_txreq);

  // R6
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_txreq |-> $past(cs && !wr_n && rd_n));

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past((ev_tx_done && cfg_setup0[0]) || (ev_rx_done && cfg_setup0[1]) ||
                           (ev_overrun && cfg_setup0[2]) || (err_rise && cfg_setup0[3])));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !intclr) |=> !irq_n);
endmodule

bind hostbus_regif hostbus_regif_chk #(.WIN_HI(WIN_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs(cs), .wr_n(wr_n), .rd_n(rd_n),
  .addr_bus(addr_bus), .cfg_setup0(cfg_setup0), .cfg_setup1(cfg_setup1),
  .cmd_txreq(cmd_txreq), .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
  .ev_overrun(ev_overrun), .err_rise(err_rise), .intclr(intclr), .irq_n(irq_n)
);

// File: tb/hostbus_regif_bench.sv
module hostbus_regif_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b1, cs = 1'b0, wr_n = 1'b1, rd_n = 1'b1, ale = 1'b0;
  logic [7:0] addr_bus = '0, data_in = '0;
  logic [7:0] data_out;
  logic data_oe;
  logic ev_tx_done = 0, ev_rx_done = 0, ev_overrun = 0, err_passive = 0, bus_off = 0;
  logic [7:0] stat_main = 8'h3C, stat_rx = 8'h71, err_cnt_tx = 8'h81, err_cnt_rx = 8'h07;
  logic [7:0] cfg_setup0, cfg_setup1, cfg_timing;
  logic [2:0] cfg_rsj;
  logic [10:0] acc_mask, trig_id;
  logic cmd_txreq, cmd_abort, cmd_ctrl_rst, cmd_rxclr_all;
  logic [2:0] cmd_rxclr;
  logic irq_n;

  always #2 clk = ~clk;

  hostbus_regif u_hostbus_regif (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs(cs), .wr_n(wr_n), .rd_n(rd_n),
    .ale(ale), .addr_bus(addr_bus), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done), .ev_overrun(ev_overrun),
    .err_passive(err_passive), .bus_off(bus_off), .stat_main(stat_main), .stat_rx(stat_rx),
    .err_cnt_tx(err_cnt_tx), .err_cnt_rx(err_cnt_rx), .cfg_setup0(cfg_setup0),
    .cfg_setup1(cfg_setup1), .cfg_timing(cfg_timing), .cfg_rsj(cfg_rsj),
    .acc_mask(acc_mask), .trig_id(trig_id), .cmd_txreq(cmd_txreq), .cmd_abort(cmd_abort),
    .cmd_ctrl_rst(cmd_ctrl_rst), .cmd_rxclr_all(cmd_rxclr_all), .cmd_rxclr(cmd_rxclr),
    .irq_n(irq_n)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb_q[$];
  event mon_ev;
  logic [7:0] mon_val;
  logic mon_oe;

  // pulse counters sampled away from the active edge
  int c_tx = 0, c_ab = 0, c_cr = 0, c_ra = 0;
  int c_rb[3] = '{0, 0, 0};
  always @(negedge clk) begin
    if (cmd_txreq) c_tx++;
    if (cmd_abort) c_ab++;
    if (cmd_ctrl_rst) c_cr++;
    if (cmd_rxclr_all) c_ra++;
    for (int b = 0; b < 3; b++) if (cmd_rxclr[b]) c_rb[b]++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results
  initial begin
    forever begin
      @(mon_ev);
      if (sb_q.size() == 0) chk("scoreboard empty", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.tag, " oe"}, {31'b0, mon_oe}, 1);
        chk(e.tag, {24'b0, mon_val}, {24'b0, e.exp});
      end
    end
  end

  task automatic set_addr(input bit m, input logic [15:0] a);
    @(negedge clk);
    mode_sel = m;
    if (!m) begin
      addr_bus = a[15:8]; data_in = a[7:0]; ale = 1'b1;
      @(negedge clk);
      ale = 1'b0;
    end else begin
      addr_bus = a[7:0];
    end
  endtask

  task automatic bus_wr(input bit m, input logic [15:0] a, input logic [7:0] d,
                        input int n = 3, input bit cs_v = 1, input bit rd_v = 1);
    set_addr(m, a);
    data_in = d; cs = cs_v; rd_n = rd_v; wr_n = 1'b0;
    repeat (n) @(negedge clk);
    wr_n = 1'b1; cs = 1'b0; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input bit m, input logic [15:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    set_addr(m, a);
    cs = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    mon_val = data_out; mon_oe = data_oe;
    -> mon_ev;
    #0;
    rd_n = 1'b1; cs = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_ev(input int which);
    @(negedge clk);
    case (which)
      0: ev_tx_done = 1;
      1: ev_rx_done = 1;
      default: ev_overrun = 1;
    endcase
    @(negedge clk);
    ev_tx_done = 0; ev_rx_done = 0; ev_overrun = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_n", irq_n, 1);
    chk("R5 idle oe", data_oe, 0);
    bus_rd(1, 16'h00, 8'h00, "R1 setup0");
    bus_rd(1, 16'h01, 8'h80, "R1 setup1");
    bus_rd(1, 16'h02, 8'h59, "R1 timing");
    bus_rd(1, 16'h03, 8'h02, "R1 ctrl rsj");
    bus_rd(1, 16'h07, 8'h00, "R1 mask hi");
    bus_rd(1, 16'h08, 8'h00, "R1 mask lo");
    bus_rd(1, 16'h0B, 8'h00, "R1 trig hi");
    bus_rd(1, 16'h0C, 8'h00, "R1 trig lo");

    // R2 plain bus, ALE ignored
    bus_wr(1, 16'h01, 8'h3C);
    bus_rd(1, 16'h01, 8'h3C, "R2 setup1");
    @(negedge clk); ale = 1'b1;
    bus_wr(1, 16'h02, 8'h77);
    @(negedge clk); ale = 1'b0;
    bus_rd(1, 16'h02, 8'h77, "R2 ale ignored");
    chk("R2 timing port", cfg_timing, 8'h77);

    // R11 split fields
    bus_wr(1, 16'h07, 8'hA5);
    bus_wr(1, 16'h08, 8'hFF);
    chk("R11 acc_mask", acc_mask, 11'h52F);
    bus_rd(1, 16'h08, 8'hE0, "R11 mask lo readback");
    bus_wr(1, 16'h0B, 8'h12);
    bus_wr(1, 16'h0C, 8'h40);
    chk("R11 trig_id", trig_id, 11'h092);
    bus_rd(1, 16'h0C, 8'h40, "R11 trig lo readback");

    // R10 status, read-only, unmapped
    bus_wr(1, 16'h05, 8'hFF);
    bus_rd(1, 16'h05, 8'h3C, "R10 stat_main");
    bus_rd(1, 16'h06, 8'h71, "R10 stat_rx");
    bus_rd(1, 16'h09, 8'h81, "R10 err tx");
    bus_rd(1, 16'h0A, 8'h07, "R10 err rx");
    bus_wr(1, 16'h10, 8'h99);
    bus_rd(1, 16'h10, 8'h00, "R10 unmapped");
    bus_rd(1, 16'h4C, 8'h00, "R10 last addr");

    // R3 multiplexed mode
    bus_wr(0, 16'h8001, 8'h11);
    bus_rd(0, 16'h8001, 8'h11, "R3 window write");
    bus_wr(0, 16'h8101, 8'h22);
    chk("R3 out-of-window write", cfg_setup1, 8'h11);
    bus_rd(0, 16'h8101, 8'h00, "R3 out-of-window read");
    bus_wr(0, 16'h8002, 8'h33);
    chk("R3 timing", cfg_timing, 8'h33);

    // R4 write gating
    bus_wr(1, 16'h01, 8'h44, 3, 0, 1);
    chk("R4 cs low", cfg_setup1, 8'h11);
    bus_wr(1, 16'h01, 8'h55, 3, 1, 0);
    chk("R4 rd low", cfg_setup1, 8'h11);

    // R5 output enable
    set_addr(1, 16'h01);
    cs = 1; rd_n = 0; wr_n = 0;
    @(negedge clk);
    chk("R5 rd+wr oe", data_oe, 0);
    wr_n = 1; cs = 0;
    @(negedge clk);
    chk("R5 cs low oe", data_oe, 0);
    cs = 1;
    @(negedge clk);
    chk("R5 read oe", data_oe, 1);
    chk("R5 read data", data_out, 8'h11);
    cs = 0; rd_n = 1;
    @(negedge clk);

    // R6 command pulses
    bus_wr(1, 16'h03, 8'h08, 6);
    chk("R6 long write txreq count", c_tx, 1);
    chk("R6 abort untouched", c_ab, 0);
    bus_rd(1, 16'h03, 8'h00, "R6 cmd not stored");
    bus_wr(1, 16'h03, 8'hFD, 4);
    chk("R6 txreq", c_tx, 2);
    chk("R6 abort", c_ab, 1);
    chk("R6 ctrl rst", c_cr, 1);
    chk("R6 rxclr all", c_ra, 1);
    bus_rd(1, 16'h03, 8'h05, "R6 rsj only");

    // R7 per-buffer clears
    bus_wr(1, 16'h04, 8'h05);
    chk("R7 buf0", c_rb[0], 1);
    chk("R7 buf1", c_rb[1], 0);
    chk("R7 buf2", c_rb[2], 1);
    bus_rd(1, 16'h04, 8'h00, "R7 reads zero");

    // R8 interrupt sources
    bus_wr(1, 16'h00, 8'h01);
    pulse_ev(1);
    chk("R8 disabled rx", irq_n, 1);
    pulse_ev(0);
    chk("R8 tx sets", irq_n, 0);
    repeat (5) @(negedge clk);
    chk("R8 held", irq_n, 0);
    bus_wr(1, 16'h03, 8'h22);
    chk("R8 cleared", irq_n, 1);
    bus_wr(1, 16'h00, 8'h06);
    pulse_ev(2);
    chk("R8 overrun sets", irq_n, 0);
    bus_wr(1, 16'h03, 8'h22);
    pulse_ev(1);
    chk("R8 rx sets", irq_n, 0);
    bus_wr(1, 16'h03, 8'h22);
    chk("R8 cleared again", irq_n, 1);

    // R9 error edge
    bus_wr(1, 16'h00, 8'h08);
    @(negedge clk); bus_off = 1;
    @(negedge clk);
    chk("R9 bus_off rise", irq_n, 0);
    bus_wr(1, 16'h03, 8'h22);
    repeat (8) @(negedge clk);
    chk("R9 level no retrigger", irq_n, 1);
    bus_off = 0;
    @(negedge clk); err_passive = 1;
    @(negedge clk);
    chk("R9 err_passive rise", irq_n, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule